// File: doc/BRIEF.md
# Software Write-Protection Sequence Guard

This block sits beside the page-write sequencer of a parallel byte-wide nonvolatile memory. It observes every captured write transaction (address and data byte) and recognises two fixed command keys. A three-byte key turns protection on and also authorises the data bytes that follow it in the same page-load burst. A six-byte key turns protection off. For each write it tells the sequencer in the same cycle whether the byte is a command byte, which never reaches the array, and whether the byte may be written. It also gates chip-erase requests.

The protection flag is persistent in a real memory. Here it is a register loaded from a preload input during reset, so retention across power cycles can be emulated. The key matcher shares its first two steps between both keys and branches at the third byte. A byte that breaks a sequence sends the matcher back to idle, or back to step one when that byte is itself the opening key byte. Closing a page-load burst discards any partial key progress and ends any authorisation.

Top module: `swp_guard`

## Requirements
- R1: While reset (rstN low) is held, protOn follows protPreload, and the matcher is idle with no write authorisation. Both values are kept after reset is released.
- R2: When protOn is 0, a write that is not a command byte has wrAccept=1 and wrIsCmd=0 in the same cycle as wrValid.
- R3: The enable key is three writes in order: data AAh at address 555h, 55h at 2AAh, then A0h at 555h, with all 11 address bits compared. Each of the three bytes has wrIsCmd=1 and wrAccept=0. protOn is 1 from the cycle after the third byte.
- R4: When protOn is 1 and no authorisation is open, a write that is not a command byte has wrAccept=0 and wrIsCmd=0.
- R5: eraseAccept equals eraseReq while protOn is 0, and is 0 while protOn is 1.
- R6: Completing the enable key opens an authorisation. Later non-command writes are then accepted even while protected, until a burstEnd pulse closes the authorisation.
- R7: The disable key is six writes in order: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 20h@555h. Every byte has wrIsCmd=1 and wrAccept=0. protOn is 0 from the cycle after the sixth byte.
- R8: A write that does not match the expected key byte, and is not AAh@555h, returns the matcher to idle. That byte is treated as an ordinary write (wrIsCmd=0), and protOn is unchanged.
- R9: A mismatching write that is AAh@555h is itself a command byte and restarts the matcher at step one, so the key can still complete from that byte.
- R10: A burstEnd pulse returns a partially matched key to idle. A later byte that would have continued it is then an ordinary write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| protPreload | input | 1 | Protection value loaded while in reset |
| wrValid | input | 1 | A captured write is present this cycle |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data byte |
| burstEnd | input | 1 | Page-load burst closed (one-cycle pulse) |
| eraseReq | input | 1 | Chip-erase request |
| wrAccept | output | 1 | Write may be committed to the array |
| wrIsCmd | output | 1 | Write is a key byte and must be discarded |
| eraseAccept | output | 1 | Erase request may proceed |
| protOn | output | 1 | Current protection state |

## Verification
The hardest situation to reach is a restart in the middle of a key. The matcher has to sit at a later step when an opening key byte arrives, and then complete from that byte. The stimulus sends AAh@555h twice in a row and then finishes the enable key. It then proves completion indirectly: a data write that follows is accepted while protection is set. A partial key cut off by burstEnd is reached in the same way. Two key bytes are sent, then the burst is closed, and the byte that would have completed the key is shown to be an ordinary write.

// File: rtl/swp_pkg.sv
package swp_pkg;

  localparam int KEY_ADDR_W = 11;
  localparam int KEY_LEN    = 6;
  localparam int STEP_W     = $clog2(KEY_LEN);

  // Shared key layout: steps 0..1 are common, step 2 branches.
  function automatic logic [KEY_ADDR_W-1:0] keyAddr(input int unsigned s);
    case (s)
      1, 4:    keyAddr = 11'h2AA;
      default: keyAddr = 11'h555;
    endcase
  endfunction

  function automatic logic [7:0] keyData(input int unsigned s);
    case (s)
      0, 3:    keyData = 8'hAA;
      1, 4:    keyData = 8'h55;
      2:       keyData = 8'h80;
      default: keyData = 8'h20;
    endcase
  endfunction

  localparam logic [7:0] ENABLE_LAST = 8'hA0;
  localparam int         BRANCH_STEP = 2;

  // Control -> datapath strobes.
  typedef struct packed {
    logic setProt;
    logic clrProt;
    logic grantAuth;
    logic dropAuth;
  } swp_strobe_t;

  // Datapath -> control compare results.
  typedef struct packed {
    logic hitStep;
    logic hitEnable;
    logic hitStart;
  } swp_match_t;

endpackage

// File: rtl/swp_dp.sv
module swp_dp
  import swp_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              protPreload,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [STEP_W-1:0] stepIdx,
  input  swp_strobe_t       strobe,
  output swp_match_t        match,
  output logic              protOn,
  output logic              authOn
);

  logic [KEY_ADDR_W-1:0] lowAddr;
  logic [7:0]            lowData;
  logic [KEY_LEN-1:0]    stepHit;

  assign lowAddr = wrAddr[KEY_ADDR_W-1:0];
  assign lowData = wrData[7:0];

  generate
    for (genvar s = 0; s < KEY_LEN; s++) begin : g_key
      assign stepHit[s] = (lowAddr == keyAddr(s)) && (lowData == keyData(s));
    end
  endgenerate

  always_comb begin
    match.hitStep   = stepHit[stepIdx];
    match.hitStart  = stepHit[0];
    match.hitEnable = (stepIdx == STEP_W'(BRANCH_STEP)) &&
                      (lowAddr == keyAddr(BRANCH_STEP)) &&
                      (lowData == ENABLE_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      protOn <= protPreload;
    end else if (strobe.setProt) begin
      protOn <= 1'b1;
    end else if (strobe.clrProt) begin
      protOn <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      authOn <= 1'b0;
    end else if (strobe.dropAuth) begin
      authOn <= 1'b0;
    end else if (strobe.grantAuth) begin
      authOn <= 1'b1;
    end
  end

endmodule

// File: rtl/swp_ctl.sv
module swp_ctl
  import swp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic              burstEnd,
  input  swp_match_t        match,
  output logic [STEP_W-1:0] stepIdx,
  output swp_strobe_t       strobe,
  output logic              isCmd
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(KEY_LEN - 1);

  logic [STEP_W-1:0] stepNext;

  always_comb begin
    stepNext = stepIdx;
    strobe   = '0;
    isCmd    = 1'b0;
    if (wrValid) begin
      if (match.hitEnable) begin
        isCmd            = 1'b1;
        strobe.setProt   = 1'b1;
        strobe.grantAuth = 1'b1;
        stepNext         = '0;
      end else if (match.hitStep) begin
        isCmd = 1'b1;
        if (stepIdx == LAST_STEP) begin
          strobe.clrProt = 1'b1;
          stepNext       = '0;
        end else begin
          stepNext = stepIdx + 1'b1;
        end
      end else if (match.hitStart) begin
        isCmd    = 1'b1;
        stepNext = STEP_W'(1);
      end else begin
        stepNext = '0;
      end
    end
    if (burstEnd) begin
      stepNext        = '0;
      strobe.dropAuth = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stepIdx <= '0;
    else       stepIdx <= stepNext;
  end

endmodule

// File: rtl/swp_guard.sv
module swp_guard
  import swp_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              protPreload,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              burstEnd,
  input  logic              eraseReq,
  output logic              wrAccept,
  output logic              wrIsCmd,
  output logic              eraseAccept,
  output logic              protOn
);

  swp_strobe_t       strobe;
  swp_match_t        match;
  logic [STEP_W-1:0] stepIdx;
  logic              authOn;
  logic              isCmd;

  swp_ctl u_ctl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .burstEnd(burstEnd),
    .match(match), .stepIdx(stepIdx), .strobe(strobe), .isCmd(isCmd)
  );

  swp_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .protPreload(protPreload),
    .wrAddr(wrAddr), .wrData(wrData), .stepIdx(stepIdx),
    .strobe(strobe), .match(match), .protOn(protOn), .authOn(authOn)
  );

  assign wrIsCmd     = isCmd;
  assign wrAccept    = wrValid && !isCmd && (!protOn || authOn);
  assign eraseAccept = eraseReq && !protOn;

endmodule

// File: rtl/swp_guard_chk.sv
module swp_guard_chk (
  input logic clk,
  input logic rstN,
  input logic wrValid,
  input logic burstEnd,
  input logic eraseReq,
  input logic wrAccept,
  input logic wrIsCmd,
  input logic eraseAccept,
  input logic protOn
);

  p_cmd_discarded_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrIsCmd |-> !wrAccept);

  p_erase_blocked_r5: assert property (@(posedge clk) disable iff (!rstN)
    protOn |-> !eraseAccept);

  p_open_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!protOn && wrValid && !wrIsCmd) |-> wrAccept);

  p_prot_moves_on_key_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(protOn) |-> $past(wrValid && wrIsCmd));

  p_auth_closed_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(burstEnd) && protOn && wrValid && !wrIsCmd) |-> !wrAccept);

  p_cmd_needs_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrIsCmd |-> wrValid);

endmodule

bind swp_guard swp_guard_chk u_chk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .burstEnd(burstEnd),
  .eraseReq(eraseReq), .wrAccept(wrAccept), .wrIsCmd(wrIsCmd),
  .eraseAccept(eraseAccept), .protOn(protOn)
);

// File: tb/swp_guard_bench.sv
`timescale 1ns/1ps
module swp_guard_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        protPreload = 1'b0;
  logic        wrValid = 1'b0;
  logic [10:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        burstEnd = 1'b0;
  logic        eraseReq = 1'b0;
  logic        wrAccept, wrIsCmd, eraseAccept, protOn;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  swp_guard u_swp_guard (
    .clk(clk), .rstN(rstN), .protPreload(protPreload), .wrValid(wrValid),
    .wrAddr(wrAddr), .wrData(wrData), .burstEnd(burstEnd),
    .eraseReq(eraseReq), .wrAccept(wrAccept), .wrIsCmd(wrIsCmd),
    .eraseAccept(eraseAccept), .protOn(protOn)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic doReset(input logic pre);
    @(negedge clk);
    rstN = 1'b0; protPreload = pre;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d,
                    input logic expAcc, input logic expCmd, input string req);
    @(negedge clk);
    wrValid = 1'b1; wrAddr = a; wrData = d;
    #1;
    chk(req, "wrAccept", wrAccept, expAcc);
    chk(req, "wrIsCmd", wrIsCmd, expCmd);
    @(posedge clk); #1;
    wrValid = 1'b0;
  endtask

  task automatic closeBurst();
    @(negedge clk); burstEnd = 1'b1;
    @(posedge clk); #1; burstEnd = 1'b0;
  endtask

  task automatic tryErase(input logic expAcc, input string req);
    @(negedge clk); eraseReq = 1'b1; #1;
    chk(req, "eraseAccept", eraseAccept, expAcc);
    @(posedge clk); #1; eraseReq = 1'b0;
  endtask

  task automatic checkProt(input logic exp, input string req);
    @(negedge clk);
    chk(req, "protOn", protOn, exp);
  endtask

  task automatic testReset();
    doReset(1'b1);
    checkProt(1'b1, "R1");
    doReset(1'b0);
    checkProt(1'b0, "R1");
    wr(11'h100, 8'h12, 1'b1, 1'b0, "R2");
    tryErase(1'b1, "R5");
  endtask

  task automatic testEnable();
    wr(11'h555, 8'hAA, 1'b0, 1'b1, "R3");
    wr(11'h2AA, 8'h55, 1'b0, 1'b1, "R3");
    wr(11'h555, 8'hA0, 1'b0, 1'b1, "R3");
    checkProt(1'b1, "R3");
    wr(11'h010, 8'h5A, 1'b1, 1'b0, "R6");
    wr(11'h03F, 8'h77, 1'b1, 1'b0, "R6");
    closeBurst();
    wr(11'h040, 8'h11, 1'b0, 1'b0, "R4");
    tryErase(1'b0, "R5");
    checkProt(1'b1, "R4");
  endtask

  task automatic testMismatch();
    wr(11'h555, 8'hAA, 1'b0, 1'b1, "R8");
    wr(11'h2AA, 8'h55, 1'b0, 1'b1, "R8");
    wr(11'h555, 8'h33, 1'b0, 1'b0, "R8");
    wr(11'h555, 8'hA0, 1'b0, 1'b0, "R8");
    checkProt(1'b1, "R8");
    closeBurst();
  endtask

  task automatic testRestart();
    wr(11'h555, 8'hAA, 1'b0, 1'b1, "R9");
    wr(11'h555, 8'hAA, 1'b0, 1'b1, "R9");
    wr(11'h2AA, 8'h55, 1'b0, 1'b1, "R9");
    wr(11'h555, 8'hA0, 1'b0, 1'b1, "R9");
    wr(11'h200, 8'h44, 1'b1, 1'b0, "R9");
    closeBurst();
  endtask

  task automatic testDisable();
    wr(11'h555, 8'hAA, 1'b0, 1'b1, "R7");
    wr(11'h2AA, 8'h55, 1'b0, 1'b1, "R7");
    wr(11'h555, 8'h80, 1'b0, 1'b1, "R7");
    wr(11'h555, 8'hAA, 1'b0, 1'b1, "R7");
    wr(11'h2AA, 8'h55, 1'b0, 1'b1, "R7");
    wr(11'h555, 8'h20, 1'b0, 1'b1, "R7");
    checkProt(1'b0, "R7");
    tryErase(1'b1, "R5");
    wr(11'h123, 8'h99, 1'b1, 1'b0, "R2");
    closeBurst();
  endtask

  task automatic testBurstAbort();
    wr(11'h555, 8'hAA, 1'b0, 1'b1, "R10");
    wr(11'h2AA, 8'h55, 1'b0, 1'b1, "R10");
    closeBurst();
    wr(11'h555, 8'hA0, 1'b1, 1'b0, "R10");
    checkProt(1'b0, "R10");
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    testReset();
    testEnable();
    testMismatch();
    testRestart();
    testDisable();
    testBurstAbort();
    summary();
  end

endmodule